// File: doc/BRIEF.md
# Prescaled 8-bit Timer and Event Counter

An 8-bit count-up counter with three operating modes, controlled through two byte-wide registers. In timer mode it advances on a tick taken from a power-of-two divider running on the system clock. In event mode it advances once per chosen edge of an external input. In pulse-width mode it counts divider ticks while the external input sits at its active level, and it switches itself off when that level ends.

The data register has two sides. A write goes only to a preload register. A read returns the live count. When the count passes its top value it takes the preload value again, emits a one-cycle overflow pulse for an interrupt controller, and inverts a square-wave output. The output frequency is therefore the tick rate divided by twice the number of counts between reloads. The control register selects the mode, the enable, the active edge and the divider setting.

Top module: `evt_timer8`

## Requirements
- R1: After reset the live count is 0x00, the control readback is 0x00, and both the overflow pulse and the square-wave output are low.
- R2: A write to the data register changes only the preload value. The live count read back on `count_o` is unaffected by that write.
- R3: Control bits [2:0] hold a divider code k from 0 to 7. The tick period is 2^(k+1) system clocks. In timer mode (bits [7:6] = 2'b10) the count advances by exactly one per tick.
- R4: Control bit 3 selects the external edge: 0 selects rising and 1 selects falling. In event mode (bits [7:6] = 2'b01) the count advances once per selected edge of the synchronized input, and the other edge has no effect.
- R5: When control bit 4 is 0, or when bits [7:6] are 2'b00, the count holds its value whatever the external input and divider do.
- R6: An advance from 0xFF loads the preload value into the count and raises `ovf_pulse` for exactly one cycle. With a steady setup, overflows in timer mode are (256 - N) * 2^(k+1) cycles apart, where N is the preload value.
- R7: `freq_out` inverts on every overflow and at no other time, so its period in timer mode is 2 * (256 - N) ticks.
- R8: Control bit 5 always reads back as 0. Every other control bit reads back the value last written to it.
- R9: In pulse-width mode (bits [7:6] = 2'b11) the count advances on ticks only while the synchronized input is at its active level (high when bit 3 is 0). At the trailing edge hardware clears control bit 4, after which further input pulses leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_we | input | 1 | Write strobe for the preload register |
| ctrl_we | input | 1 | Write strobe for the control register |
| wdata | input | CNT_W | Write data for both registers |
| ext_in | input | 1 | Asynchronous external event or pulse input |
| count_o | output | CNT_W | Live count (data register read side) |
| ctrl_o | output | 8 | Control register readback |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| freq_out | output | 1 | Square wave that toggles on each overflow |

## Verification
The properties assume that `ext_in` stays low through reset, so that the synchronizer does not report a false edge on the first cycle. They also assume that consecutive advances are at least two clocks apart. The divider guarantees this spacing in timer and pulse modes, and the input edge detector guarantees it in event mode. The stimulus holds each external level for at least four clocks and returns the input to its inactive level before changing the edge or mode setting. It changes the divider only while the scoreboard ignores the interval to the first overflow that follows, because the divider phase is free-running.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  localparam int CTRL_W     = 8;
  localparam int PSC_W      = 3;
  localparam int BIT_EDGE   = 3;
  localparam int BIT_EN     = 4;
  localparam int BIT_UNUSED = 5;
endpackage

// File: rtl/evt_timer8_prescaler.sv
module evt_timer8_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap_mask;

  // bits [sel:0] set: tick once every 2^(sel+1) clocks
  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      tap_mask[i] = (i <= int'(sel));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= ((div_q & tap_mask) == tap_mask);
    end
  end
endmodule

// File: rtl/evt_timer8_insync.sv
module evt_timer8_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sh_q[STAGES-1];
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/evt_timer8_regs.sv
module evt_timer8_regs
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic              ctrl_we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              clr_en,
  output logic [CNT_W-1:0]  preload,
  output logic [CTRL_W-1:0] ctrl_q,
  output tmr_mode_e         mode,
  output logic              edge_sel,
  output logic              en,
  output logic [PSC_W-1:0]  psc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      preload <= '0;
      ctrl_q  <= '0;
    end else begin
      if (data_we) preload <= wdata;
      if (ctrl_we) begin
        ctrl_q             <= wdata[CTRL_W-1:0];
        ctrl_q[BIT_UNUSED] <= 1'b0;
      end else if (clr_en) begin
        ctrl_q[BIT_EN] <= 1'b0;
      end
    end
  end

  assign mode     = tmr_mode_e'(ctrl_q[CTRL_W-1:CTRL_W-2]);
  assign edge_sel = ctrl_q[BIT_EDGE];
  assign en       = ctrl_q[BIT_EN];
  assign psc      = ctrl_q[PSC_W-1:0];
endmodule

// File: rtl/evt_timer8_count.sv
module evt_timer8_count
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_e        mode,
  input  logic             en,
  input  logic             edge_sel,
  input  logic             tick,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             freq,
  output logic             clr_en
);
  logic act_edge, trail_edge, act_lvl, step;

  assign act_edge   = edge_sel ? fall : rise;
  assign trail_edge = edge_sel ? rise : fall;
  assign act_lvl    = lvl ^ edge_sel;

  always_comb begin
    unique case (mode)
      MODE_EVENT: step = en & act_edge;
      MODE_TIMER: step = en & tick;
      MODE_PULSE: step = en & tick & act_lvl;
      default:    step = 1'b0;
    endcase
  end

  assign clr_en = en & (mode == MODE_PULSE) & trail_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
      freq  <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (step) begin
        if (&count) begin
          count <= preload;
          ovf   <= 1'b1;
          freq  <= ~freq;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evt_timer8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic              ctrl_we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              ext_in,
  output logic [CNT_W-1:0]  count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ovf_pulse,
  output logic              freq_out
);
  logic [CNT_W-1:0] preload_q;
  tmr_mode_e        mode;
  logic             edge_sel, en, clr_en;
  logic [PSC_W-1:0] psc;
  logic             tick, lvl, rise, fall;

  evt_timer8_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .data_we(data_we), .ctrl_we(ctrl_we),
    .wdata(wdata), .clr_en(clr_en), .preload(preload_q), .ctrl_q(ctrl_o),
    .mode(mode), .edge_sel(edge_sel), .en(en), .psc(psc)
  );

  evt_timer8_prescaler #(.PS_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .sel(psc), .tick(tick)
  );

  evt_timer8_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_in), .lvl(lvl), .rise(rise), .fall(fall)
  );

  evt_timer8_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .mode(mode), .en(en), .edge_sel(edge_sel),
    .tick(tick), .lvl(lvl), .rise(rise), .fall(fall), .preload(preload_q),
    .count(count_o), .ovf(ovf_pulse), .freq(freq_out), .clr_en(clr_en)
  );
endmodule

// File: rtl/evt_timer8_chk.sv
module evt_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_o,
  input logic [7:0]       ctrl_o,
  input logic             ovf_pulse,
  input logic             freq_out,
  input logic [CNT_W-1:0] preload
);
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse); // R6

  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> count_o == $past(preload)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!ovf_pulse && !$stable(count_o)) |-> count_o == CNT_W'($past(count_o) + 1'b1)); // R3

  AST_FREQ_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> !$stable(freq_out)); // R7

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ovf_pulse |-> $stable(freq_out)); // R7

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_o[4] || ctrl_o[7:6] == 2'b00) |=> $stable(count_o)); // R5

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ctrl_o[5]); // R8
endmodule

bind evt_timer8 evt_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .count_o(count_o), .ctrl_o(ctrl_o),
  .ovf_pulse(ovf_pulse), .freq_out(freq_out), .preload(preload_q)
);

// File: tb/tb_evt_timer8.sv
module tb_evt_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       data_we = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] wdata = '0;
  logic       ext_in = 1'b0;
  logic [7:0] count_o, ctrl_o;
  logic       ovf_pulse, freq_out;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] reload;
    int         gap;
  } exp_t;
  exp_t sb_q[$];

  evt_timer8 dut (
    .clk(clk), .rst(rst), .data_we(data_we), .ctrl_we(ctrl_we),
    .wdata(wdata), .ext_in(ext_in), .count_o(count_o), .ctrl_o(ctrl_o),
    .ovf_pulse(ovf_pulse), .freq_out(freq_out)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] c, input logic [7:0] pl);
    return (c == 8'hFF) ? pl : c + 8'd1;
  endfunction

  task automatic wr(input bit is_ctrl, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    if (is_ctrl) ctrl_we = 1'b1; else data_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
    data_we = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_in = 1'b1;
    repeat (4) @(negedge clk);
    ext_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] rl, input int gap);
    exp_t e;
    e.reload = rl;
    e.gap    = gap;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor: pops expected overflow items and compares
  initial begin
    int since = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      since++;
      if (!rst && ovf_pulse) begin
        if (sb_q.size() != 0) begin
          e = sb_q.pop_front();
          chk("R6 reload", count_o == e.reload, count_o, e.reload);
          if (e.gap != 0) chk("R3/R6 overflow spacing", since == e.gap, since, e.gap);
        end
        since = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0, c1, d;
    int t0, t1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 count", count_o == 8'h00, count_o, 0);
    chk("R1 ctrl", ctrl_o == 8'h00, ctrl_o, 0);
    chk("R1 ovf", ovf_pulse == 1'b0, ovf_pulse, 0);
    chk("R1 freq", freq_out == 1'b0, freq_out, 0);

    // R2: data write only loads preload
    wr(0, 8'hF0);
    @(negedge clk);
    chk("R2 count untouched", count_o == 8'h00, count_o, 0);

    // R8: unused bit reads zero, mode 00 keeps idle
    wr(1, 8'h3F);
    chk("R8 ctrl readback", ctrl_o == 8'h1F, ctrl_o, 8'h1F);

    // R3/R6/R7: timer mode, divide by 2, N=0xF0
    wr(1, 8'h90);
    push(8'hF0, 0);
    push(8'hF0, 32);
    push(8'hF0, 32);
    drain();
    @(posedge freq_out); t0 = cyc;
    @(posedge freq_out); t1 = cyc;
    chk("R7 freq period", (t1 - t0) == 64, t1 - t0, 64);

    // R3: divide by 16
    wr(1, 8'h93);
    push(8'hF0, 0);
    push(8'hF0, 256);
    push(8'hF0, 256);
    drain();

    // R5: mode 00 holds
    wr(1, 8'h00);
    c0 = count_o;
    repeat (300) @(negedge clk);
    chk("R5 idle hold", count_o == c0, count_o, c0);

    // R4: event mode, rising edge, preload 0xFD
    wr(0, 8'hFD);
    wr(1, 8'h50);
    c0 = count_o;
    for (int i = 0; i < 5; i++) begin
      pulse_ext();
      c0 = nxt(c0, 8'hFD);
    end
    repeat (4) @(negedge clk);
    chk("R4 rising events", count_o == c0, count_o, c0);

    // R4: falling edge select
    wr(1, 8'h58);
    c0 = count_o;
    ext_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 rising ignored", count_o == c0, count_o, c0);
    ext_in = 1'b0;
    repeat (6) @(negedge clk);
    c0 = nxt(c0, 8'hFD);
    chk("R4 falling counted", count_o == c0, count_o, c0);

    // R5: enable low
    wr(1, 8'h48);
    c0 = count_o;
    for (int i = 0; i < 3; i++) pulse_ext();
    chk("R5 disabled hold", count_o == c0, count_o, c0);
    // R5: mode 00 with enable high
    wr(1, 8'h10);
    for (int i = 0; i < 3; i++) pulse_ext();
    chk("R5 mode00 hold", count_o == c0, count_o, c0);

    // R9: pulse-width mode, active high, divide by 2
    wr(0, 8'h00);
    wr(1, 8'hD0);
    c0 = count_o;
    repeat (40) @(negedge clk);
    chk("R9 inactive level hold", count_o == c0, count_o, c0);
    ext_in = 1'b1;
    repeat (200) @(negedge clk);
    ext_in = 1'b0;
    repeat (8) @(negedge clk);
    c1 = count_o;
    d = c1 - c0;
    chk("R9 pulse width ticks", (d >= 8'd99) && (d <= 8'd101), d, 100);
    chk("R9 enable auto-clear", ctrl_o == 8'hC0, ctrl_o, 8'hC0);
    pulse_ext();
    repeat (4) @(negedge clk);
    chk("R9 stopped after trail", count_o == c1, count_o, c1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule